// File: doc/BRIEF.md
# Segment Descriptor Address Translator

The translator converts a segmented virtual address, made of a 16-bit selector and a 32-bit offset, into a 32-bit linear address. It finds the 8-byte descriptor for the selector in either the global or the local descriptor table. It reads that descriptor as two 32-bit words over a simple word-read memory port and keeps the segment base, limit and access rights in a one-entry cache. It then adds the offset to the base and checks the offset against the limit.

When paging is off, the linear address also goes out as the physical address. When paging is on, only the linear address is presented, for a later page-translation stage. A request is accepted when `req_valid` is high while `req_ready` is high. While the selector matches the last descriptor loaded, the cached copy is reused and memory is not read again.

Top module: `seg_xlate`

## Requirements
- R1: During and directly after reset, `req_ready` is 1 and `mem_rd`, `lin_valid`, `phys_valid` and `limit_fault` are 0.
- R2: Selector bit 2 picks the table. 1 selects `ldt_base` and 0 selects `gdt_base`. The descriptor address is that base plus selector bits 15:3 times 8. The first read goes to this address and the second read to the address plus 4.
- R3: The first descriptor word is the 32-bit segment base. In the second word, bits 19:0 are the limit and bits 31:20 are the access rights. The access rights appear on `seg_rights` with the result.
- R4: `lin_addr` is the segment base plus the offset, modulo 2^32.
- R5: On a cache miss with no wait states, the result is a one-cycle pulse that appears after the third rising edge following the accepting edge. Each cycle that `mem_ack` stays low on a pending read adds one cycle.
- R6: If the selector equals the selector of the last loaded descriptor, no memory read is made. The result appears after the first rising edge following the accepting edge.
- R7: An offset greater than the limit raises `limit_fault` for one cycle, with `lin_valid` and `phys_valid` low. An offset equal to the limit is valid.
- R8: When `paging_on` is 0, `phys_valid` pulses with `lin_valid` and `phys_addr` equals `lin_addr`. When `paging_on` is 1, `lin_valid` pulses and `phys_valid` stays 0.
- R9: With each result, `out_rpl` shows selector bits 1:0 and `out_ti` shows selector bit 2.
- R10: `req_ready` is 0 from the accepting edge until the result cycle. A `req_valid` seen while `req_ready` is 0 is ignored.
- R11: A read that has not been acknowledged keeps `mem_rd` high and `mem_addr` unchanged until `mem_ack` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| paging_on | input | 1 | Paging enabled; suppresses the physical output |
| gdt_base | input | 32 | Global descriptor table base |
| ldt_base | input | 32 | Local descriptor table base |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block is idle and can accept a request |
| req_sel | input | 16 | Segment selector |
| req_off | input | 32 | Offset within the segment |
| mem_rd | output | 1 | Descriptor word read request |
| mem_addr | output | 32 | Descriptor word byte address |
| mem_ack | input | 1 | Read data valid this cycle |
| mem_rdata | input | 32 | Read data |
| lin_valid | output | 1 | Linear address valid pulse |
| lin_addr | output | 32 | Linear address |
| phys_valid | output | 1 | Physical address valid pulse |
| phys_addr | output | 32 | Physical address |
| limit_fault | output | 1 | Offset exceeded the segment limit |
| out_rpl | output | 2 | Requested privilege level of the result |
| out_ti | output | 1 | Table indicator of the result |
| seg_rights | output | 12 | Access rights of the segment |

## Verification
A cache hit produces its result one edge after acceptance. A miss with zero-wait memory needs three edges. Each wait state on either of the two reads adds one edge. The bench drives each request at a falling edge and counts falling edges until a result appears. It samples on the expected falling edge and compares the measured count against these figures, so a response that comes early or late fails on latency as well as on value. Fault and paging results follow the same hit and miss timing. The busy-request case checks that no second pulse appears in the two cycles after the real result.

// File: rtl/seg_pkg.sv
package seg_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RD0  = 2'd1,
      ST_RD1  = 2'd2,
      ST_CALC = 2'd3
   } seg_st_e;

   localparam int TI_BIT  = 2;
   localparam int RPL_W   = 2;
   localparam int DESC_SH = 3;
endpackage

// File: rtl/seg_desc_addr.sv
module seg_desc_addr
   import seg_pkg::*;
#(
   parameter int AW    = 32,
   parameter int SEL_W = 16
) (
   input  logic [SEL_W-1:0] sel,
   input  logic [AW-1:0]    gdt_base,
   input  logic [AW-1:0]    ldt_base,
   output logic [AW-1:0]    desc_addr,
   output logic             ti,
   output logic [RPL_W-1:0] rpl
);
   localparam int IDX_W = SEL_W - DESC_SH;
   localparam int PAD_W = AW - IDX_W - DESC_SH;

   if (PAD_W < 0) begin : g_bad_width
      $error("seg_desc_addr: selector index does not fit in the address width");
   end

   logic [IDX_W-1:0] idx;
   logic [AW-1:0]    tbl_base;

   assign idx       = sel[SEL_W-1:DESC_SH];
   assign ti        = sel[TI_BIT];
   assign rpl       = sel[RPL_W-1:0];
   assign tbl_base  = ti ? ldt_base : gdt_base;
   assign desc_addr = tbl_base + {{PAD_W{1'b0}}, idx, {DESC_SH{1'b0}}};
endmodule

// File: rtl/seg_fetch_fsm.sv
module seg_fetch_fsm
   import seg_pkg::*;
#(
   parameter int AW       = 32,
   parameter int SEL_W    = 16,
   parameter int LIMIT_W  = 20,
   parameter int RIGHTS_W = 12,
   parameter bit REUSE    = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic [SEL_W-1:0]    req_sel,
   input  logic [AW-1:0]       req_off,
   input  logic [AW-1:0]       desc_addr,
   input  logic                mem_ack,
   input  logic [AW-1:0]       mem_rdata,
   output logic                req_ready,
   output logic                mem_rd,
   output logic [AW-1:0]       mem_addr,
   output logic [SEL_W-1:0]    cur_sel,
   output logic [AW-1:0]       cur_off,
   output logic                calc_go,
   output logic [AW-1:0]       c_base,
   output logic [LIMIT_W-1:0]  c_limit,
   output logic [RIGHTS_W-1:0] c_rights
);
   localparam logic [AW-1:0] WORD_STEP = AW'(AW / 8);

   seg_st_e          st;
   logic             cache_vld;
   logic [SEL_W-1:0] cache_sel;
   logic             hit;

   if (REUSE) begin : g_reuse
      assign hit = cache_vld && (cache_sel == req_sel);
   end else begin : g_refetch
      assign hit = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         cache_vld <= 1'b0;
         cache_sel <= '0;
         cur_sel   <= '0;
         cur_off   <= '0;
         c_base    <= '0;
         c_limit   <= '0;
         c_rights  <= '0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (req_valid) begin
                  cur_sel <= req_sel;
                  cur_off <= req_off;
                  if (hit) begin
                     st <= ST_CALC;
                  end else begin
                     st        <= ST_RD0;
                     cache_vld <= 1'b0;
                  end
               end
            end
            ST_RD0: begin
               if (mem_ack) begin
                  c_base <= mem_rdata;
                  st     <= ST_RD1;
               end
            end
            ST_RD1: begin
               if (mem_ack) begin
                  c_limit   <= mem_rdata[LIMIT_W-1:0];
                  c_rights  <= mem_rdata[AW-1:LIMIT_W];
                  cache_vld <= 1'b1;
                  cache_sel <= cur_sel;
                  st        <= ST_CALC;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (st == ST_IDLE);
   assign mem_rd    = (st == ST_RD0) || (st == ST_RD1);
   assign mem_addr  = (st == ST_RD1) ? desc_addr + WORD_STEP : desc_addr;
   assign calc_go   = (st == ST_CALC);
endmodule

// File: rtl/seg_add_chk.sv
module seg_add_chk
   import seg_pkg::*;
#(
   parameter int AW       = 32,
   parameter int LIMIT_W  = 20,
   parameter int RIGHTS_W = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                go,
   input  logic                paging_on,
   input  logic [AW-1:0]       off,
   input  logic [AW-1:0]       base,
   input  logic [LIMIT_W-1:0]  limit,
   input  logic [RIGHTS_W-1:0] rights,
   input  logic                ti_in,
   input  logic [RPL_W-1:0]    rpl_in,
   output logic                lin_valid,
   output logic [AW-1:0]       lin_addr,
   output logic                phys_valid,
   output logic [AW-1:0]       phys_addr,
   output logic                limit_fault,
   output logic [RPL_W-1:0]    out_rpl,
   output logic                out_ti,
   output logic [RIGHTS_W-1:0] seg_rights
);
   logic [AW-1:0] sum;
   logic          over;

   assign sum  = base + off;
   assign over = off > {{(AW-LIMIT_W){1'b0}}, limit};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lin_valid   <= 1'b0;
         phys_valid  <= 1'b0;
         limit_fault <= 1'b0;
         lin_addr    <= '0;
         phys_addr   <= '0;
         out_rpl     <= '0;
         out_ti      <= 1'b0;
         seg_rights  <= '0;
      end else begin
         lin_valid   <= go && !over;
         phys_valid  <= go && !over && !paging_on;
         limit_fault <= go && over;
         if (go) begin
            lin_addr   <= sum;
            phys_addr  <= paging_on ? '0 : sum;
            out_rpl    <= rpl_in;
            out_ti     <= ti_in;
            seg_rights <= rights;
         end
      end
   end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
   import seg_pkg::*;
#(
   parameter int AW       = 32,
   parameter int SEL_W    = 16,
   parameter int LIMIT_W  = 20,
   parameter int RIGHTS_W = 12,
   parameter bit REUSE    = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                paging_on,
   input  logic [AW-1:0]       gdt_base,
   input  logic [AW-1:0]       ldt_base,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic [SEL_W-1:0]    req_sel,
   input  logic [AW-1:0]       req_off,
   output logic                mem_rd,
   output logic [AW-1:0]       mem_addr,
   input  logic                mem_ack,
   input  logic [AW-1:0]       mem_rdata,
   output logic                lin_valid,
   output logic [AW-1:0]       lin_addr,
   output logic                phys_valid,
   output logic [AW-1:0]       phys_addr,
   output logic                limit_fault,
   output logic [RPL_W-1:0]    out_rpl,
   output logic                out_ti,
   output logic [RIGHTS_W-1:0] seg_rights
);
   if (LIMIT_W + RIGHTS_W != AW) begin : g_bad_desc
      $error("seg_xlate: limit and rights must fill one descriptor word");
   end
   if (SEL_W <= DESC_SH) begin : g_bad_sel
      $error("seg_xlate: selector too narrow");
   end

   logic [SEL_W-1:0]    cur_sel;
   logic [AW-1:0]       cur_off;
   logic [AW-1:0]       desc_addr;
   logic                calc_go;
   logic [AW-1:0]       c_base;
   logic [LIMIT_W-1:0]  c_limit;
   logic [RIGHTS_W-1:0] c_rights;
   logic                cur_ti;
   logic [RPL_W-1:0]    cur_rpl;

   seg_desc_addr #(.AW(AW), .SEL_W(SEL_W)) u_daddr (
      .sel       (cur_sel),
      .gdt_base  (gdt_base),
      .ldt_base  (ldt_base),
      .desc_addr (desc_addr),
      .ti        (cur_ti),
      .rpl       (cur_rpl)
   );

   seg_fetch_fsm #(
      .AW(AW), .SEL_W(SEL_W), .LIMIT_W(LIMIT_W), .RIGHTS_W(RIGHTS_W), .REUSE(REUSE)
   ) u_fetch (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_sel   (req_sel),
      .req_off   (req_off),
      .desc_addr (desc_addr),
      .mem_ack   (mem_ack),
      .mem_rdata (mem_rdata),
      .req_ready (req_ready),
      .mem_rd    (mem_rd),
      .mem_addr  (mem_addr),
      .cur_sel   (cur_sel),
      .cur_off   (cur_off),
      .calc_go   (calc_go),
      .c_base    (c_base),
      .c_limit   (c_limit),
      .c_rights  (c_rights)
   );

   seg_add_chk #(.AW(AW), .LIMIT_W(LIMIT_W), .RIGHTS_W(RIGHTS_W)) u_add (
      .clk         (clk),
      .rst_n       (rst_n),
      .go          (calc_go),
      .paging_on   (paging_on),
      .off         (cur_off),
      .base        (c_base),
      .limit       (c_limit),
      .rights      (c_rights),
      .ti_in       (cur_ti),
      .rpl_in      (cur_rpl),
      .lin_valid   (lin_valid),
      .lin_addr    (lin_addr),
      .phys_valid  (phys_valid),
      .phys_addr   (phys_addr),
      .limit_fault (limit_fault),
      .out_rpl     (out_rpl),
      .out_ti      (out_ti),
      .seg_rights  (seg_rights)
   );
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
   parameter int AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_ready,
   input logic          mem_rd,
   input logic          mem_ack,
   input logic [AW-1:0] mem_addr,
   input logic          lin_valid,
   input logic [AW-1:0] lin_addr,
   input logic          phys_valid,
   input logic [AW-1:0] phys_addr,
   input logic          limit_fault
);
   // R7
   fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      limit_fault |-> (!lin_valid && !phys_valid));

   // R8
   phys_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phys_valid |-> (lin_valid && phys_addr == lin_addr));

   // R11
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && !mem_ack) |=> (mem_rd && $stable(mem_addr)));

   // R10
   busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd |-> !req_ready);

   // R10
   result_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lin_valid || limit_fault) |-> req_ready);

   // R5
   pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lin_valid |=> !lin_valid);
endmodule

bind seg_xlate seg_xlate_chk #(.AW(AW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .req_ready   (req_ready),
   .mem_rd      (mem_rd),
   .mem_ack     (mem_ack),
   .mem_addr    (mem_addr),
   .lin_valid   (lin_valid),
   .lin_addr    (lin_addr),
   .phys_valid  (phys_valid),
   .phys_addr   (phys_addr),
   .limit_fault (limit_fault)
);

// File: tb/seg_xlate_bench.sv
module seg_xlate_bench;
   localparam logic [31:0] GDT_B = 32'h0001_0000;
   localparam logic [31:0] LDT_B = 32'h0002_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        paging_on = 1'b0;
   logic        req_valid = 1'b0;
   logic [15:0] req_sel = '0;
   logic [31:0] req_off = '0;
   logic        req_ready, mem_rd, mem_ack;
   logic [31:0] mem_addr, mem_rdata;
   logic        lin_valid, phys_valid, limit_fault, out_ti;
   logic [31:0] lin_addr, phys_addr;
   logic [1:0]  out_rpl;
   logic [11:0] seg_rights;

   int checks = 0;
   int errors = 0;
   int stall_cfg = 0;
   int wait_cnt;
   int rd_cnt;
   logic [31:0] rd_log [0:15];
   logic [31:0] m_addr [0:7];
   logic [31:0] m_data [0:7];
   int m_used = 0;

   always #5 clk = ~clk;

   seg_xlate u_seg_xlate (
      .clk(clk), .rst_n(rst_n), .paging_on(paging_on),
      .gdt_base(GDT_B), .ldt_base(LDT_B),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_sel(req_sel), .req_off(req_off),
      .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .lin_valid(lin_valid), .lin_addr(lin_addr),
      .phys_valid(phys_valid), .phys_addr(phys_addr),
      .limit_fault(limit_fault), .out_rpl(out_rpl), .out_ti(out_ti),
      .seg_rights(seg_rights)
   );

   // memory model
   assign mem_ack = mem_rd && (wait_cnt >= stall_cfg);
   always_comb begin
      mem_rdata = 32'hDEAD_BEEF;
      for (int i = 0; i < 8; i++)
         if (i < m_used && m_addr[i] == mem_addr) mem_rdata = m_data[i];
   end
   always @(posedge clk) begin
      if (!rst_n) begin
         wait_cnt <= 0;
         rd_cnt   <= 0;
      end else begin
         if (mem_rd && !mem_ack) wait_cnt <= wait_cnt + 1;
         else wait_cnt <= 0;
         if (mem_rd && mem_ack) begin
            rd_log[rd_cnt % 16] <= mem_addr;
            rd_cnt <= rd_cnt + 1;
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic put_desc(input logic [31:0] a, input logic [31:0] base,
                           input logic [19:0] lim, input logic [11:0] rights);
      m_addr[m_used] = a;      m_data[m_used] = base;            m_used++;
      m_addr[m_used] = a + 4;  m_data[m_used] = {rights, lim};   m_used++;
   endtask

   // issues one request and returns the falling-edge count until a result
   task automatic do_req(input logic [15:0] sel, input logic [31:0] off, output int lat);
      @(negedge clk);
      req_valid = 1'b1; req_sel = sel; req_off = off;
      @(posedge clk);
      lat = 0;
      for (int n = 1; n <= 40; n++) begin
         @(negedge clk);
         req_valid = 1'b0;
         if (lin_valid || limit_fault) begin
            lat = n;
            break;
         end
      end
   endtask

   task automatic t_reset();
      // R1
      chk("R1 ready", 32'(req_ready), 32'd1);
      chk("R1 mem_rd", 32'(mem_rd), 32'd0);
      chk("R1 valid/fault", {29'd0, lin_valid, phys_valid, limit_fault}, 32'd0);
   endtask

   task automatic t_global_miss();
      int lat, r0;
      r0 = rd_cnt;
      do_req(16'h002B, 32'h0000_2000, lat);
      chk("R5 miss latency", 32'(lat), 32'd4);
      chk("R4 lin_addr", lin_addr, 32'h0003_2000);
      chk("R2 reads", 32'(rd_cnt - r0), 32'd2);
      chk("R2 first addr", rd_log[r0 % 16], GDT_B + 32'h28);
      chk("R2 second addr", rd_log[(r0 + 1) % 16], GDT_B + 32'h2C);
      chk("R3 rights", 32'(seg_rights), 32'h09A);
      chk("R9 rpl/ti", {29'd0, out_ti, out_rpl}, 32'h3);
      chk("R8 phys", {31'd0, phys_valid}, 32'd1);
      chk("R8 phys_addr", phys_addr, 32'h0003_2000);
      @(negedge clk);
      chk("R5 pulse", 32'(lin_valid), 32'd0);
   endtask

   task automatic t_hit();
      int lat, r0;
      r0 = rd_cnt;
      do_req(16'h002B, 32'h0000_1234, lat);
      chk("R6 hit latency", 32'(lat), 32'd2);
      chk("R6 no reads", 32'(rd_cnt - r0), 32'd0);
      chk("R6 lin_addr", lin_addr, 32'h0003_1234);
   endtask

   task automatic t_local_edge();
      int lat, r0;
      r0 = rd_cnt;
      do_req(16'h003D, 32'h000F_FFFF, lat);
      chk("R5 local latency", 32'(lat), 32'd4);
      chk("R2 local addr", rd_log[r0 % 16], LDT_B + 32'h38);
      chk("R2 local addr2", rd_log[(r0 + 1) % 16], LDT_B + 32'h3C);
      chk("R7 equal ok", {30'd0, lin_valid, limit_fault}, 32'h2);
      chk("R4 local lin", lin_addr, 32'h800F_FFFF);
      chk("R9 local rpl/ti", {29'd0, out_ti, out_rpl}, 32'h5);
      chk("R3 local rights", 32'(seg_rights), 32'hF00);
   endtask

   task automatic t_fault();
      int lat;
      do_req(16'h003D, 32'h0010_0000, lat);
      chk("R7 fault latency", 32'(lat), 32'd2);
      chk("R7 fault flags", {29'd0, limit_fault, lin_valid, phys_valid}, 32'h4);
   endtask

   task automatic t_wrap();
      int lat, r0;
      r0 = rd_cnt;
      do_req(16'hFFF8, 32'h0000_2000, lat);
      chk("R2 top index addr", rd_log[r0 % 16], GDT_B + 32'hFFF8);
      chk("R4 wrap", lin_addr, 32'h0000_1000);
      chk("R5 wrap latency", 32'(lat), 32'd4);
   endtask

   task automatic t_paging();
      int lat;
      paging_on = 1'b1;
      do_req(16'hFFF8, 32'h0000_0010, lat);
      chk("R8 paging lin", {31'd0, lin_valid}, 32'd1);
      chk("R8 paging phys off", {31'd0, phys_valid}, 32'd0);
      chk("R8 paging lin_addr", lin_addr, 32'hFFFF_F010);
      paging_on = 1'b0;
   endtask

   task automatic t_stall();
      int lat;
      stall_cfg = 3;
      do_req(16'h002B, 32'h0000_0004, lat);
      chk("R11 stall latency", 32'(lat), 32'd10);
      chk("R11 stall lin", lin_addr, 32'h0003_0004);
      stall_cfg = 0;
   endtask

   task automatic t_busy();
      int seen;
      @(negedge clk);
      req_valid = 1'b1; req_sel = 16'h003D; req_off = 32'h0000_0010;
      @(posedge clk);
      @(negedge clk);
      req_sel = 16'h002B; req_off = 32'h0000_0999;
      chk("R10 busy ready 1", 32'(req_ready), 32'd0);
      @(negedge clk);
      chk("R10 busy ready 2", 32'(req_ready), 32'd0);
      @(negedge clk);
      chk("R10 busy ready 3", 32'(req_ready), 32'd0);
      req_valid = 1'b0;
      @(negedge clk);
      chk("R10 result valid", {31'd0, lin_valid}, 32'd1);
      chk("R10 result addr", lin_addr, 32'h8000_0010);
      seen = 0;
      for (int k = 0; k < 2; k++) begin
         @(negedge clk);
         if (lin_valid || limit_fault) seen++;
      end
      chk("R10 ignored request", 32'(seen), 32'd0);
   endtask

   initial begin
      for (int c = 0; c < 20000; c++) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      put_desc(GDT_B + 32'h28,   32'h0003_0000, 20'h0FFFF, 12'h09A);
      put_desc(LDT_B + 32'h38,   32'h8000_0000, 20'hFFFFF, 12'hF00);
      put_desc(GDT_B + 32'hFFF8, 32'hFFFF_F000, 20'hFFFFF, 12'h0F2);
      repeat (3) @(posedge clk);
      @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_global_miss();
      t_hit();
      t_local_edge();
      t_fault();
      t_wrap();
      t_paging();
      t_stall();
      t_busy();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule